// File: doc/BRIEF.md
# Eight-bit Timer with Compare Match and Interrupt Flags

The block is an 8-bit up-counter that advances on cycles where a count-enable input is high. A compare register is checked against the counter on every count step. A match is raised only when counting brings the counter onto the compare value. When the clear-on-match input is high, that same step loads zero into the counter instead. Wrapping from 0xFF to 0x00 by counting is an overflow event.

Each event sets a sticky flag. A mask register chooses which flags may request an interrupt, and a global interrupt-enable input gates the request. The request output carries the vector number of the highest-priority pending source. Software reaches the counter, compare, mask and flag registers through a simple write strobe, an address, write data and a registered read port.

Top module: `tcm_timer8`

## Requirements
- R1: After synchronous reset the counter, mask, flags, read data, request and vector are 0, and the compare register holds 0xFF.
- R2: On a cycle with `cnt_en` high the counter steps up by one, modulo 256. With `cnt_en` low it holds its value.
- R3: A bus write to the counter (address 0x2E) takes priority over counting in that cycle and never sets the compare or overflow flag. Writing the compare register to the counter's present value raises no match either. A compare write in a counting cycle takes effect after that cycle's comparison.
- R4: When a count step makes the counter equal the compare register (address 0x2D), flag bit 6 of the flag register (address 0x38) becomes 1.
- R5: With `clr_mode` high, a count step that matches loads 0 into the counter instead of the compare value. Such a step never sets the overflow flag, even when it wraps from 0xFF.
- R6: A count step from 0xFF to 0x00 that is not an R5 clear sets flag bit 2, whatever the mask and `gie` are.
- R7: Writing 1 to flag bit 6 or bit 2 clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R8: Bits 6 to 1 of the mask register (address 0x39) are readable and writable, and mask bits 7 and 0 read 0. Flag register bits other than 6 and 2 read 0.
- R9: `irq_req` is registered. It is 1 one cycle after `gie` is high while an unmasked flag is set, with mask bit 6 paired to flag bit 6 and mask bit 2 paired to flag bit 2. `irq_vec` is 3 when the compare source is pending and enabled, otherwise 4 when overflow is, and 0 when there is no request.
- R10: `rdata` is registered. It presents, one cycle later, the register at the address sampled on the previous edge, as the register stood before that edge. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter step enable |
| clr_mode | input | 1 | Clear counter on compare match |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector number of the request |

## Verification
A wrong counter value shows at the counter read address on the read that follows. It shows on the flag register no later than the count step that should have reached the compare value or 0xFF. A wrong compare detection, for example a match on a bus write or a missed clear-on-match, shows as a flag bit that differs from the expected value one cycle after the event. It also shows on `irq_req` and `irq_vec` one cycle after that, when the source is enabled. Comparing every output on every cycle against a reference model catches such a divergence within two cycles of its cause.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam logic [7:0] ADR_CMP = 8'h2D;
  localparam logic [7:0] ADR_CNT = 8'h2E;
  localparam logic [7:0] ADR_FLG = 8'h38;
  localparam logic [7:0] ADR_MSK = 8'h39;
  localparam int unsigned BIT_CMP = 6;
  localparam int unsigned BIT_OVF = 2;
  localparam int unsigned VEC_CMP = 3;
  localparam int unsigned VEC_OVF = 4;
endpackage

// File: rtl/tcm_counter.sv
module tcm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr_mode,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic         hit,
  output logic         wrap
);
  logic         step;
  logic [W-1:0] inc;

  always_comb begin
    step = en & ~cnt_wr;
    inc  = cnt + 1'b1;
    hit  = step & (inc == cmp);
    wrap = step & (cnt == {W{1'b1}}) & ~(hit & clr_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cmp <= '1;
    end else begin
      if (cnt_wr)
        cnt <= wdata;
      else if (en)
        cnt <= (hit && clr_mode) ? '0 : inc;
      if (cmp_wr)
        cmp <= wdata;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(cnt));
  assert_write_wins_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt == $past(wdata));
  assert_match_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr_mode) |=> cnt == $past(cmp));
  assert_clear_on_match_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && clr_mode) |=> cnt == '0);
  assert_no_wrap_on_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && clr_mode) |-> !wrap);
  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == '0);
endmodule

// File: rtl/tcm_irq_regs.sv
module tcm_irq_regs #(
  parameter int unsigned W       = 8,
  parameter int unsigned VW      = 3,
  parameter int unsigned BIT_CMP = 6,
  parameter int unsigned BIT_OVF = 2,
  parameter int unsigned VEC_CMP = 3,
  parameter int unsigned VEC_OVF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          wrap,
  input  logic          msk_wr,
  input  logic          flg_wr,
  input  logic [W-1:0]  wdata,
  input  logic          gie,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  flags,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  localparam logic [W-1:0] MASK_RW = {1'b0, {(W-2){1'b1}}, 1'b0};

  logic flg_cmp, flg_ovf;
  logic pend_cmp, pend_ovf;

  always_comb begin
    flags          = '0;
    flags[BIT_CMP] = flg_cmp;
    flags[BIT_OVF] = flg_ovf;
    pend_cmp       = flg_cmp & mask[BIT_CMP];
    pend_ovf       = flg_ovf & mask[BIT_OVF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      flg_cmp <= 1'b0;
      flg_ovf <= 1'b0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      if (msk_wr)
        mask <= wdata & MASK_RW;
      flg_cmp <= hit  | (flg_cmp & ~(flg_wr & wdata[BIT_CMP]));
      flg_ovf <= wrap | (flg_ovf & ~(flg_wr & wdata[BIT_OVF]));
      irq_req <= gie & (pend_cmp | pend_ovf);
      if (!gie)
        irq_vec <= '0;
      else if (pend_cmp)
        irq_vec <= VW'(VEC_CMP);
      else if (pend_ovf)
        irq_vec <= VW'(VEC_OVF);
      else
        irq_vec <= '0;
    end
  end

  assert_match_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> flags[BIT_CMP]);
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flags[BIT_OVF]);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flags[BIT_CMP] && !flg_wr) |=> flags[BIT_CMP]);
  assert_no_spurious_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (!hit && !flags[BIT_CMP]) |=> !flags[BIT_CMP]);
  assert_req_needs_gie_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));
  assert_vec_valid_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == VW'(VEC_CMP) || irq_vec == VW'(VEC_OVF)));
endmodule

// File: rtl/tcm_timer8.sv
module tcm_timer8
  import tcm_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned VW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          clr_mode,
  input  logic          gie,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  rdata,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  localparam logic [AW-1:0] A_CMP = AW'(ADR_CMP);
  localparam logic [AW-1:0] A_CNT = AW'(ADR_CNT);
  localparam logic [AW-1:0] A_FLG = AW'(ADR_FLG);
  localparam logic [AW-1:0] A_MSK = AW'(ADR_MSK);

  logic [W-1:0] cnt, cmp, mask, flags;
  logic         hit, wrap;
  logic         cnt_wr, cmp_wr, msk_wr, flg_wr;

  always_comb begin
    cnt_wr = bus_we && (bus_addr == A_CNT);
    cmp_wr = bus_we && (bus_addr == A_CMP);
    msk_wr = bus_we && (bus_addr == A_MSK);
    flg_wr = bus_we && (bus_addr == A_FLG);
  end

  tcm_counter #(.W(W)) i_counter (
    .clk(clk), .rst(rst), .en(cnt_en), .clr_mode(clr_mode),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wdata(bus_wdata),
    .cnt(cnt), .cmp(cmp), .hit(hit), .wrap(wrap)
  );

  tcm_irq_regs #(
    .W(W), .VW(VW), .BIT_CMP(BIT_CMP), .BIT_OVF(BIT_OVF),
    .VEC_CMP(VEC_CMP), .VEC_OVF(VEC_OVF)
  ) i_irq (
    .clk(clk), .rst(rst), .hit(hit), .wrap(wrap),
    .msk_wr(msk_wr), .flg_wr(flg_wr), .wdata(bus_wdata), .gie(gie),
    .mask(mask), .flags(flags), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else begin
      case (bus_addr)
        A_CMP:   rdata <= cmp;
        A_CNT:   rdata <= cnt;
        A_FLG:   rdata <= flags;
        A_MSK:   rdata <= mask;
        default: rdata <= '0;
      endcase
    end
  end

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_MSK || bus_addr == A_FLG) |=> (!rdata[W-1] && !rdata[0]));
  assert_unused_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != A_MSK && bus_addr != A_FLG && bus_addr != A_CMP &&
     bus_addr != A_CNT) |=> rdata == '0);
endmodule

// File: tb/test_tcm_timer8.sv
module test_tcm_timer8;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CMP = 8'h2D;
  localparam logic [7:0] A_CNT = 8'h2E;
  localparam logic [7:0] A_FLG = 8'h38;
  localparam logic [7:0] A_MSK = 8'h39;

  logic       clk = 1'b0, rst = 1'b1;
  logic       cnt_en = 1'b0, clr_mode = 1'b0, gie = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] rdata;
  logic       irq_req;
  logic [2:0] irq_vec;

  int    errors = 0, checks = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  logic [7:0] m_cnt = 8'h00, m_cmp = 8'hFF, m_mask = 8'h00, m_flag = 8'h00;

  tcm_timer8 i_tcm_timer8 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .clr_mode(clr_mode), .gie(gie),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      A_CMP:   return m_cmp;
      A_CNT:   return m_cnt;
      A_FLG:   return m_flag;
      A_MSK:   return m_mask;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] model_vec(input logic ie);
    if (!ie) return 3'd0;
    if (m_flag[6] && m_mask[6]) return 3'd3;
    if (m_flag[2] && m_mask[2]) return 3'd4;
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a,
                      input logic [7:0] d, input logic en);
    logic [7:0] exp_rd, n, ncnt, f;
    logic [2:0] exp_vec;
    logic hit, ov;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; cnt_en = en;
    exp_rd  = model_read(a);
    exp_vec = model_vec(gie);
    hit = 1'b0; ov = 1'b0; ncnt = m_cnt;
    if (we && a == A_CNT) ncnt = d;
    else if (en) begin
      n = m_cnt + 8'd1;
      hit = (n == m_cmp);
      ncnt = (hit && clr_mode) ? 8'h00 : n;
      ov = (m_cnt == 8'hFF) && !(hit && clr_mode);
    end
    f = m_flag;
    if (we && a == A_FLG) f = f & ~d;
    if (hit) f[6] = 1'b1;
    if (ov)  f[2] = 1'b1;
    @(posedge clk);
    m_cnt  = ncnt;
    m_flag = f & 8'h44;
    if (we && a == A_CMP) m_cmp = d;
    if (we && a == A_MSK) m_mask = d & 8'h7E;
    #1;
    chk(cur_tag, "rdata", rdata, exp_rd);
    chk("R9", "irq_req", {7'd0, irq_req}, {7'd0, exp_vec != 3'd0});
    chk("R9", "irq_vec", {5'd0, irq_vec}, {5'd0, exp_vec});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state at the ports and in every register
    chk("R1", "rdata after reset", rdata, 8'h00);
    chk("R1", "irq_req after reset", {7'd0, irq_req}, 8'h00);
    cur_tag = "R1";
    rd(A_CNT); rd(A_CMP); rd(A_MSK); rd(A_FLG); rd(A_FLG);

    // R2: hold without enable, step with enable
    cur_tag = "R2";
    wr(A_CNT, 8'h40);
    repeat (3) step(1'b0, A_CNT, 8'h00, 1'b0);
    repeat (4) step(1'b0, A_CNT, 8'h00, 1'b1);

    // R3: bus-made equality raises no match
    cur_tag = "R3";
    wr(A_CMP, 8'h50); wr(A_CNT, 8'h50); rd(A_FLG); rd(A_FLG);
    wr(A_CNT, 8'h60); wr(A_CMP, 8'h60); rd(A_FLG); rd(A_FLG);
    wr(A_CMP, 8'h50);
    step(1'b1, A_CNT, 8'h4F, 1'b1);
    rd(A_FLG); rd(A_CNT);

    // R4: counting into the compare value sets bit 6
    cur_tag = "R4";
    wr(A_CNT, 8'h4E);
    step(1'b0, A_FLG, 8'h00, 1'b1);
    step(1'b0, A_FLG, 8'h00, 1'b1);
    rd(A_FLG); rd(A_CNT);

    // R7: write-one-to-clear, set beats clear
    cur_tag = "R7";
    wr(A_FLG, 8'h00); rd(A_FLG);
    wr(A_FLG, 8'h40); rd(A_FLG);
    wr(A_CNT, 8'h4F);
    step(1'b1, A_FLG, 8'h44, 1'b1);
    rd(A_FLG);

    // R6: wrap sets bit 2 regardless of mask
    cur_tag = "R6";
    wr(A_FLG, 8'hFF); wr(A_MSK, 8'h00); wr(A_CNT, 8'hFE);
    repeat (3) step(1'b0, A_FLG, 8'h00, 1'b1);
    rd(A_FLG);

    // R5: clear on match, wrap-clear raises no overflow
    cur_tag = "R5";
    clr_mode = 1'b1;
    wr(A_FLG, 8'hFF); wr(A_CMP, 8'h03); wr(A_CNT, 8'h00);
    repeat (8) step(1'b0, A_CNT, 8'h00, 1'b1);
    wr(A_FLG, 8'hFF); wr(A_CMP, 8'h00); wr(A_CNT, 8'hFE);
    repeat (3) step(1'b0, A_FLG, 8'h00, 1'b1);
    rd(A_FLG); rd(A_CNT);
    clr_mode = 1'b0;

    // R8: mask bits 6..1 writable, reserved bits read zero
    cur_tag = "R8";
    wr(A_MSK, 8'hFF); rd(A_MSK);
    wr(A_MSK, 8'h81); rd(A_MSK);
    wr(A_FLG, 8'hFF); rd(A_FLG);

    // R9: request needs enable bit and gie; compare has priority
    cur_tag = "R9";
    wr(A_CMP, 8'h10); wr(A_CNT, 8'hFE);
    repeat (20) step(1'b0, A_FLG, 8'h00, 1'b1);
    wr(A_MSK, 8'h44); rd(A_FLG); rd(A_FLG);
    gie = 1'b1; rd(A_FLG); rd(A_FLG);
    wr(A_FLG, 8'h40); rd(A_FLG); rd(A_FLG);
    wr(A_MSK, 8'h40); rd(A_FLG); rd(A_FLG);
    gie = 1'b0; rd(A_FLG); rd(A_FLG);

    // R10: random traffic, unused addresses included
    cur_tag = "R10";
    for (int blk = 0; blk < 8; blk++) begin
      clr_mode = blk[0];
      for (int i = 0; i < 400; i++) begin
        logic [7:0] a;
        logic [7:0] d;
        logic       w;
        case ($urandom % 6)
          0: a = A_CMP;
          1: a = A_CNT;
          2: a = A_FLG;
          3: a = A_MSK;
          default: a = 8'($urandom);
        endcase
        d = 8'($urandom);
        w = ($urandom % 8) == 0;
        if (w && a == A_CMP && d < 8'h08) d = 8'h08 + d;
        gie = ($urandom % 4) != 0;
        step(w, a, d, ($urandom % 4) != 0);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule